// File: doc/BRIEF.md
# Sector Bit-Flip Corrector for an 8-Error BCH Result

This block finishes the work of a hardware BCH decoder that protects one 512-byte sector with 13 check bytes and can locate up to eight bad bits. The decoder leaves behind three 32-bit result words and a status word. Together they hold an error count and up to eight 13-bit error locations, packed end to end. The corrector unpacks those locations and applies a fixed bit-order adjustment to each one. It discards any location that points past the sector's data bits. For each remaining location it inverts one bit of the sector buffer, using a byte-wide read-modify-write port.

A host pulses `start_i` with the result words present on the inputs, and the block captures them. The block then walks the first N locations in index order, where N is the count. Each valid location costs one read cycle and one write-back cycle, and each invalid location costs one idle step. When the walk ends, the block raises `done_o` for one cycle. At that point the number of bits actually flipped, or an uncorrectable flag, is available on the outputs and stays there until the next start.

Top module: `bchfix_top`

## Requirements
- R1: While reset is held and in the first cycles after it, `busy_o`, `done_o`, `mem_rd_o`, `mem_wr_o`, `uncorrectable_o` and `fixed_count_o` are all zero.
- R2: When the count field, `status_i[13:10]`, is zero at start, the block makes no memory access, pulses `done_o`, and reports a fixed count of 0 with the uncorrectable flag clear.
- R3: When the count field is 9 to 15, the block makes no memory access, pulses `done_o`, raises `uncorrectable_o` and reports a fixed count of 0.
- R4: The 104-bit location field is the concatenation {`status_i[23:16]`, word2, word1, word0}, with word0 in the least significant bits. Location k occupies bits 13k+12 down to 13k. As a result, locations 2, 4 and 7 each span two source words.
- R5: Each raw location is XORed with 3 before it is used as a bit address.
- R6: An adjusted location of 4096 or more causes no memory access and is not counted.
- R7: A valid adjusted location L reads byte L>>3 with `mem_rd_o`. In the next cycle it writes back the same address with `mem_wr_o`, inverting bit L&7 of the data returned on `mem_rdata_i`. Read data arrives one cycle after the read strobe.
- R8: Only locations 0 to N-1 are used, where N is the count, and they are applied in increasing index order. A bit hit twice ends up restored.
- R9: `done_o` is high for exactly one cycle after the last correction. At that point `fixed_count_o` equals the number of bits flipped.
- R10: A start pulse while `busy_o` is high is ignored and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Capture the result words and begin correction (ignored while busy) |
| res_word0_i | input | 32 | Result word holding locations 0, 1 and low part of 2 |
| res_word1_i | input | 32 | Result word holding rest of 2, location 3, low part of 4 |
| res_word2_i | input | 32 | Result word holding rest of 4, locations 5, 6, low part of 7 |
| status_i | input | 32 | Count in bits 13:10, high 8 bits of location 7 in bits 23:16 |
| mem_addr_o | output | 9 | Byte address for read and write-back |
| mem_rd_o | output | 1 | Read strobe; data expected on `mem_rdata_i` next cycle |
| mem_wr_o | output | 1 | Write strobe for `mem_wdata_o` |
| mem_wdata_o | output | 8 | Corrected byte |
| mem_rdata_i | input | 8 | Byte returned by the buffer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fixed_count_o | output | 4 | Number of bits flipped by the last operation |
| uncorrectable_o | output | 1 | Last operation had a count above 8 |

## Verification
The assertions assume that the sector buffer behaves as a synchronous memory with a one-cycle read latency and that nothing else writes to it while `busy_o` is high. The bench's buffer model keeps to this by updating only on the block's own strobes. The assertions also assume that `status_i` and the result words are meaningful only in the start cycle. The stimulus changes them freely in all other cycles, including during a run, which is how R10 is exercised. Locations are generated from target bit positions, so that in-range values, the 4095/4096 edge, repeated bytes and word-spanning fields are all reached.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
  // Status word layout: count field and high-location field positions.
  localparam int CNT_LSB  = 10;
  localparam int CNT_W    = 4;
  localparam int HI_LSB   = 16;
  // Bit-order adjustment applied to every raw location.
  localparam int LOC_ADJ  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WB   = 2'd2,
    ST_FIN  = 2'd3
  } fix_state_t;
endpackage

// File: rtl/bchfix_rstsync.sv
module bchfix_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bchfix_unpack.sv
module bchfix_unpack #(
  parameter int WORD_W      = 32,
  parameter int LOC_W       = 13,
  parameter int MAX_LOCS    = 8,
  parameter int SECTOR_BITS = 4096,
  localparam int PACK_W     = LOC_W * MAX_LOCS,
  localparam int HI_W       = PACK_W - 3 * WORD_W
) (
  input  logic [WORD_W-1:0]                 word0_i,
  input  logic [WORD_W-1:0]                 word1_i,
  input  logic [WORD_W-1:0]                 word2_i,
  input  logic [HI_W-1:0]                   hi_i,
  output logic [MAX_LOCS-1:0][LOC_W-1:0]    loc_o,
  output logic [MAX_LOCS-1:0]               valid_o
);
  import bchfix_pkg::*;

  logic [PACK_W-1:0] packed_w;
  assign packed_w = {hi_i, word2_i, word1_i, word0_i};

  for (genvar g = 0; g < MAX_LOCS; g++) begin : g_loc
    logic [LOC_W-1:0] raw_w;
    assign raw_w      = packed_w[g*LOC_W +: LOC_W];
    assign loc_o[g]   = raw_w ^ LOC_W'(LOC_ADJ);
    assign valid_o[g] = (loc_o[g] < LOC_W'(SECTOR_BITS));
  end
endmodule

// File: rtl/bchfix_seq.sv
module bchfix_seq #(
  parameter int LOC_W    = 13,
  parameter int MAX_LOCS = 8,
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  localparam int SEL_W   = $clog2(MAX_LOCS),
  localparam int BIT_W   = $clog2(DATA_W)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [CNT_W-1:0]               cnt_field_i,
  input  logic [MAX_LOCS-1:0][LOC_W-1:0] locs_i,
  input  logic [MAX_LOCS-1:0]            valid_i,
  output logic                           take_o,
  output logic [ADDR_W-1:0]              mem_addr_o,
  output logic                           mem_rd_o,
  output logic                           mem_wr_o,
  output logic [DATA_W-1:0]              mem_wdata_o,
  input  logic [DATA_W-1:0]              mem_rdata_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [CNT_W-1:0]               fixed_o,
  output logic                           unc_o
);
  import bchfix_pkg::*;

  fix_state_t       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] n_q, n_d;
  logic [CNT_W-1:0] fixed_q, fixed_d;
  logic             unc_q, unc_d;
  logic             adv_en;

  logic [SEL_W-1:0] sel_w;
  logic [LOC_W-1:0] cur_loc;
  logic [DATA_W-1:0] flip_mask;

  assign sel_w     = (idx_q < CNT_W'(MAX_LOCS)) ? idx_q[SEL_W-1:0] : '0;
  assign cur_loc   = locs_i[sel_w];
  assign flip_mask = DATA_W'(1) << cur_loc[BIT_W-1:0];

  // Next-state and output decode.
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    n_d      = n_q;
    fixed_d  = fixed_q;
    unc_d    = unc_q;
    take_o   = 1'b0;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          take_o  = 1'b1;
          fixed_d = '0;
          unc_d   = 1'b0;
          idx_d   = '0;
          n_d     = cnt_field_i;
          if (cnt_field_i == '0) begin
            state_d = ST_FIN;
          end else if (cnt_field_i > CNT_W'(MAX_LOCS)) begin
            unc_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            state_d = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (idx_q == n_q) begin
          state_d = ST_FIN;
        end else if (valid_i[sel_w]) begin
          mem_rd_o = 1'b1;
          state_d  = ST_WB;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_WB: begin
        mem_wr_o = 1'b1;
        idx_d    = idx_q + 1'b1;
        fixed_d  = fixed_q + 1'b1;
        state_d  = ST_SCAN;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign adv_en = (state_q != ST_IDLE) || start_i;

  // State registers with explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      n_q     <= '0;
      fixed_q <= '0;
      unc_q   <= 1'b0;
    end else if (adv_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      n_q     <= n_d;
      fixed_q <= fixed_d;
      unc_q   <= unc_d;
    end
  end

  assign mem_addr_o  = cur_loc[BIT_W +: ADDR_W];
  assign mem_wdata_o = mem_rdata_i ^ flip_mask;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign fixed_o     = fixed_q;
  assign unc_o       = unc_q;

  logic unused_loc_hi;
  assign unused_loc_hi = ^cur_loc[LOC_W-1:BIT_W+ADDR_W];

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> $past(mem_rd_o)); // R7
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_addr_o == $past(mem_addr_o))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_FIXED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_o <= CNT_W'(MAX_LOCS)); // R9
  AST_UNC_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    unc_o |-> (fixed_o == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(mem_rd_o || mem_wr_o)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(n_q)); // R10
endmodule

// File: rtl/bchfix_top.sv
module bchfix_top #(
  parameter int WORD_W       = 32,
  parameter int LOC_W        = 13,
  parameter int MAX_LOCS     = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int SECTOR_BITS = SECTOR_BYTES * DATA_W,
  localparam int HI_W        = LOC_W * MAX_LOCS - 3 * WORD_W,
  localparam int CNT_W       = bchfix_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] res_word0_i,
  input  logic [WORD_W-1:0] res_word1_i,
  input  logic [WORD_W-1:0] res_word2_i,
  input  logic [WORD_W-1:0] status_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  fixed_count_o,
  output logic              uncorrectable_o
);
  import bchfix_pkg::*;

  logic rst_n_s;
  logic take_w;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q;
  logic [HI_W-1:0]   hi_q;
  logic [MAX_LOCS-1:0][LOC_W-1:0] locs_w;
  logic [MAX_LOCS-1:0]            valid_w;

  bchfix_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Capture the result words on an accepted start.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      w0_q <= '0;
      w1_q <= '0;
      w2_q <= '0;
      hi_q <= '0;
    end else if (take_w) begin
      w0_q <= res_word0_i;
      w1_q <= res_word1_i;
      w2_q <= res_word2_i;
      hi_q <= status_i[HI_LSB +: HI_W];
    end
  end

  logic unused_stat;
  assign unused_stat = ^{status_i[WORD_W-1:HI_LSB+HI_W],
                         status_i[HI_LSB-1:CNT_LSB+CNT_W],
                         status_i[CNT_LSB-1:0]};

  bchfix_unpack #(
    .WORD_W      (WORD_W),
    .LOC_W       (LOC_W),
    .MAX_LOCS    (MAX_LOCS),
    .SECTOR_BITS (SECTOR_BITS)
  ) u_unpack (
    .word0_i (w0_q),
    .word1_i (w1_q),
    .word2_i (w2_q),
    .hi_i    (hi_q),
    .loc_o   (locs_w),
    .valid_o (valid_w)
  );

  bchfix_seq #(
    .LOC_W    (LOC_W),
    .MAX_LOCS (MAX_LOCS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .cnt_field_i (status_i[CNT_LSB +: CNT_W]),
    .locs_i      (locs_w),
    .valid_i     (valid_w),
    .take_o      (take_w),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fixed_o     (fixed_count_o),
    .unc_o       (uncorrectable_o)
  );
endmodule

// File: tb/bchfix_top_tb_top.sv
module bchfix_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] w0, w1, w2, st;
  logic [8:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done, unc;
  logic [3:0]  fixed;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_tag = "R1";
  bit   watch_en = 0;

  logic [7:0] mem     [512];
  logic [7:0] exp_mem [512];
  int q_addr[$];
  int q_data[$];

  bchfix_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .res_word0_i(w0), .res_word1_i(w1), .res_word2_i(w2), .status_i(st),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .fixed_count_o(fixed), .uncorrectable_o(unc)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Buffer model: synchronous read, one cycle latency.
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  // Reference comparison on every clock.
  always @(negedge clk) begin
    if (watch_en && rst_n) begin
      if (mem_rd) begin
        check({cur_tag, " read"}, q_addr.size() > 0 && int'(mem_addr) == q_addr[0],
              int'(mem_addr), q_addr.size() > 0 ? q_addr[0] : -1);
      end
      if (mem_wr) begin
        if (q_addr.size() == 0) begin
          check({cur_tag, " unexpected write"}, 1'b0, int'(mem_addr), -1);
        end else begin
          check({cur_tag, " write addr"}, int'(mem_addr) == q_addr[0], int'(mem_addr), q_addr[0]);
          check({cur_tag, " write data"}, int'(mem_wdata) == q_data[0], int'(mem_wdata), q_data[0]);
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      check("watchdog", 1'b0, cycles, 0);
      summary();
      $finish;
    end
  end

  // R4 packing: location k at bits 13k+12..13k of {st[23:16], w2, w1, w0}.
  task automatic pack(input int raw[8], input int n);
    logic [103:0] v;
    v = '0;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 13; b++) v[k*13+b] = raw[k][b];
    w0 = v[31:0];
    w1 = v[63:32];
    w2 = v[95:64];
    st = 32'hA5000000 | (32'(v[103:96]) << 16) | (32'(n) << 10) | 32'h0000_03C1;
  endtask

  task automatic run_op(input string tag, input int raw[8], input int n, input bit hit_busy);
    int exp_cnt = 0;
    int waited = 0;
    bit exp_unc;
    cur_tag = tag;
    exp_unc = (n > 8);
    if (n <= 8) begin
      for (int k = 0; k < n; k++) begin
        int adj = raw[k] ^ 3;
        if (adj < 4096) begin
          int a = adj >> 3;
          exp_mem[a] = exp_mem[a] ^ (8'd1 << (adj & 7));
          q_addr.push_back(a);
          q_data.push_back(int'(exp_mem[a]));
          exp_cnt++;
        end
      end
    end
    @(negedge clk);
    pack(raw, n);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    w0 = 32'hFFFF_FFFF; w1 = 32'h1234_5678; w2 = 32'h0; st = 32'hFFFF_FFFF;
    if (hit_busy) begin
      int alt[8] = '{3, 3, 3, 3, 3, 3, 3, 3};
      pack(alt, 7);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " done seen"}, done === 1'b1, int'(done), 1);
    check({tag, " fixed count"}, int'(fixed) == exp_cnt, int'(fixed), exp_cnt);
    check({tag, " uncorrectable"}, unc == exp_unc, int'(unc), int'(exp_unc));
    check({tag, " pending corrections"}, q_addr.size() == 0, q_addr.size(), 0);
    @(negedge clk);
    check({tag, " R9 done one cycle"}, done == 1'b0, int'(done), 0);
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
      check({tag, " buffer contents"}, bad == 0, bad, 0);
    end
    if (hit_busy) begin
      int extra = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      check({tag, " R10 no second run"}, extra == 0, extra, 0);
    end
  endtask

  initial begin
    int r[8];
    rst_n = 0; start_i = 0; w0 = 0; w1 = 0; w2 = 0; st = 0;
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 37 + 11) & 8'hFF);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy == 0, int'(busy), 0);
    check("R1 done in reset", done == 0, int'(done), 0);
    check("R1 mem strobes in reset", !mem_rd && !mem_wr, int'({mem_rd, mem_wr}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 outputs after reset", !busy && !done && fixed == 0 && !unc,
          int'({busy, done, unc, fixed}), 0);
    watch_en = 1;

    // R2: count zero, locations populated but no access.
    r = '{5, 100, 200, 300, 400, 500, 600, 700};
    run_op("R2", r, 0, 0);
    // R3: counts above limit.
    run_op("R3 n9", r, 9, 0);
    run_op("R3 n15", r, 15, 0);
    // R5 R7: raw 0 -> bit 3 of byte 0; raw 4 -> bit 7 of byte 0.
    r = '{0, 4, 0, 0, 0, 0, 0, 0};
    run_op("R5 R7", r, 2, 0);
    // R4: eight valid locations, including word-spanning ones.
    r = '{(17^3), (1000^3), (4000^3), (2049^3), (3071^3), (513^3), (77^3), (4093^3)};
    run_op("R4", r, 8, 0);
    // R6: out-of-range edges 4096 and 8188 skipped, 4095 and 0 applied.
    r = '{(4096^3), (4095^3), 8191, (0^3), 0, 0, 0, 0};
    run_op("R6", r, 4, 0);
    // R8: only first two of eight valid locations, plus repeated bits.
    r = '{(900^3), (40^3), (8^3), (16^3), (24^3), (32^3), (48^3), (56^3)};
    run_op("R8 subset", r, 2, 0);
    r = '{(10^3), (13^3), (10^3), 0, 0, 0, 0, 0};
    run_op("R8 same byte", r, 3, 0);
    // R10: second start while busy must be ignored.
    r = '{(1234^3), (2345^3), (3456^3), (123^3), 0, 0, 0, 0};
    run_op("R10", r, 4, 1);
    // R9: single location at top of sector.
    r = '{(4094^3), 0, 0, 0, 0, 0, 0, 0};
    run_op("R9", r, 1, 0);

    summary();
    $finish;
  end
endmodule